// File: doc/BRIEF.md
# Three-Stage Pipelined Datapath with Operand Bypass

This block is a short overlapped datapath. Decoded instructions (opcode, destination index, two source indices and a valid bit) enter an operand-read stage, move to an execute stage and finish in a writeback stage. They run over a register file with two read ports and one write port. While one instruction reads its operands, the instruction ahead of it executes and the one before that writes back. The execute stage adds or subtracts the two operands, or forms a load address from their sum. A synchronous data memory outside the block returns the load data one cycle later.

Each of the two ALU operands passes through a priority bypass. The bypass can select the in-flight execute result, the in-flight writeback result or the register-file read. A producer supplies an operand only when it is a valid instruction and its destination equals that operand's source.

A load cannot forward from execute, because its data does not exist yet. A consumer of a load is therefore held for exactly one cycle while a bubble goes down the pipe, and the load data then reaches it. A parameter picks whether the register file shows a same-cycle write to a read (read-new) or not (read-old). The writeback bypass arm exists only in the read-old build.

Top module: `bypass_pipe`

## Requirements
- R1: Every valid instruction writes its destination exactly once. Writebacks appear on the writeback port in issue order, and each value equals the value given by executing the accepted instruction stream one at a time in order.
- R2: Opcode encoding: 2'b00 writes a+b, 2'b01 writes a-b, 2'b10 loads the memory word at address (a+b) modulo 2^AW, and 2'b11 executes as an add. All arithmetic is modulo 2^DW. a is the value of the first source and b the value of the second. The memory returns the word one clock after the cycle in which mem_rd is high.
- R3: An instruction that reads the destination of the add or subtract issued just before it receives that fresh result with no stall.
- R4: When the two instructions ahead of a consumer both write its source, the consumer receives the value of the more recent one.
- R5: A consumer issued two slots after its producer (the producer is in writeback) receives the new value. This holds for a load producer as well, and for both register-file read policies.
- R6: A consumer issued three or more slots after its producer reads the updated register file.
- R7: A bubble (in_valid low) writes nothing and forwards nothing, whatever its index fields hold.
- R8: A load in execute whose destination equals either source of the valid instruction in operand read raises in_hold for exactly one cycle. A load followed by an instruction that does not read its destination raises no hold.
- R9: While in_hold is high, the instruction on the input is not taken. It is taken on a later cycle and executed exactly once.
- R10: Reset leaves register i holding the value i, wb_valid low and in_hold low.
- R11: Register 0 is an ordinary register: it can be written and then read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input instruction is real (low = bubble) |
| in_op | input | 2 | Opcode, encoding in R2 |
| in_dst | input | RW | Destination register index |
| in_srca | input | RW | First source register index |
| in_srcb | input | RW | Second source register index |
| in_hold | output | 1 | Input instruction is not taken this cycle |
| mem_rd | output | 1 | Load read strobe to data memory |
| mem_addr | output | AW | Load address |
| mem_rdata | input | DW | Load data, valid the cycle after mem_rd |
| wb_valid | output | 1 | A result is written this cycle |
| wb_dst | output | RW | Register written |
| wb_data | output | DW | Value written |

## Verification
The bench issues dependent pairs at distances one, two and three and beyond. A design with no execute bypass would return the old register value at distance one. A read-old file with no writeback arm would return it at distance two. It also issues two writers of one register back to back ahead of a consumer, which exposes a reversed bypass priority as the older value. Loads feeding either source are measured for hold length, since a missing hold would pass on the unformed load result and a hold that repeats would lose an issue slot. Bubbles carrying matching index fields catch a bypass that ignores the valid bit. Both register-file policies run the same stream, including writes to register 0.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    OPC_ADD  = 2'b00,
    OPC_SUB  = 2'b01,
    OPC_LOAD = 2'b10,
    OPC_ADD2 = 2'b11
  } opc_e;

  function automatic logic op_is_load(opc_e op);
    return op == OPC_LOAD;
  endfunction

  function automatic logic op_subtracts(opc_e op);
    return op == OPC_SUB;
  endfunction

endpackage

// File: rtl/bp_regfile.sv
module bp_regfile #(
  parameter int DW       = 16,
  parameter int NREG     = 8,
  parameter bit READ_NEW = 1'b0,
  localparam int RW      = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0][RW-1:0]   raddr,
  output logic [1:0][DW-1:0]   rdata,
  input  logic                 we,
  input  logic [RW-1:0]        waddr,
  input  logic [DW-1:0]        wdata
);

  logic [NREG-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= DW'(i);
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    if (READ_NEW) begin : g_new
      assign rdata[p] = (we && (waddr == raddr[p])) ? wdata : regs_q[raddr[p]];
    end else begin : g_old
      assign rdata[p] = regs_q[raddr[p]];
    end
  end

  AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata)); // R1

endmodule

// File: rtl/bp_bypass.sv
module bp_bypass #(
  parameter int DW      = 16,
  parameter int RW      = 3,
  parameter bit WB_PATH = 1'b1
) (
  input  logic [RW-1:0] src,
  input  logic [DW-1:0] rf_val,
  input  logic          ex_ok,
  input  logic [RW-1:0] ex_dst,
  input  logic [DW-1:0] ex_val,
  input  logic          wb_ok,
  input  logic [RW-1:0] wb_dst,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] opnd,
  output logic          hit_ex,
  output logic          hit_wb
);

  assign hit_ex = ex_ok && (ex_dst == src);
  assign hit_wb = WB_PATH && wb_ok && (wb_dst == src);

  always_comb begin
    if (hit_ex)      opnd = ex_val;
    else if (hit_wb) opnd = wb_val;
    else             opnd = rf_val;
  end

endmodule

// File: rtl/bp_hazard.sv
module bp_hazard #(
  parameter int RW = 3
) (
  input  logic          ro_valid,
  input  logic [RW-1:0] ro_srca,
  input  logic [RW-1:0] ro_srcb,
  input  logic          ex_valid,
  input  logic          ex_is_load,
  input  logic [RW-1:0] ex_dst,
  output logic          stall
);

  logic dst_used;

  assign dst_used = (ex_dst == ro_srca) || (ex_dst == ro_srcb);
  assign stall    = ro_valid && ex_valid && ex_is_load && dst_used;

endmodule

// File: rtl/bypass_pipe.sv
module bypass_pipe
  import bp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NREG     = 8,
  parameter int AW       = 6,
  parameter bit READ_NEW = 1'b0,
  localparam int RW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_srca,
  input  logic [RW-1:0] in_srcb,
  output logic          in_hold,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_valid,
  output logic [RW-1:0] wb_dst,
  output logic [DW-1:0] wb_data
);

  localparam bit WB_FWD = !READ_NEW;

  function automatic logic [DW-1:0] alu_calc(opc_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    return op_subtracts(op) ? (a - b) : (a + b);
  endfunction

  // operand-read stage
  logic          ro_valid_q;
  opc_e          ro_op_q;
  logic [RW-1:0] ro_dst_q, ro_srca_q, ro_srcb_q;
  // execute stage
  logic          ex_valid_q;
  opc_e          ex_op_q;
  logic [RW-1:0] ex_dst_q;
  logic [DW-1:0] ex_a_q, ex_b_q;
  // writeback stage
  logic          wb_valid_q;
  opc_e          wb_op_q;
  logic [RW-1:0] wb_dst_q;
  logic [DW-1:0] wb_res_q;

  logic                 stall;
  logic                 ex_is_load, ex_fwd_ok;
  logic [DW-1:0]        ex_alu, wb_value;
  logic [1:0][RW-1:0]   ro_src;
  logic [1:0][DW-1:0]   rf_rd, opnd;
  logic [1:0]           hit_ex, hit_wb;

  assign ro_src = {ro_srcb_q, ro_srca_q};

  bp_hazard #(.RW(RW)) u_hazard (
    .ro_valid   (ro_valid_q),
    .ro_srca    (ro_srca_q),
    .ro_srcb    (ro_srcb_q),
    .ex_valid   (ex_valid_q),
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst_q),
    .stall      (stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ro_valid_q <= 1'b0;
      ro_op_q    <= OPC_ADD;
      ro_dst_q   <= '0;
      ro_srca_q  <= '0;
      ro_srcb_q  <= '0;
    end else if (!stall) begin
      ro_valid_q <= in_valid;
      ro_op_q    <= opc_e'(in_op);
      ro_dst_q   <= in_dst;
      ro_srca_q  <= in_srca;
      ro_srcb_q  <= in_srcb;
    end
  end

  bp_regfile #(.DW(DW), .NREG(NREG), .READ_NEW(READ_NEW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (ro_src),
    .rdata (rf_rd),
    .we    (wb_valid_q),
    .waddr (wb_dst_q),
    .wdata (wb_value)
  );

  assign ex_is_load = op_is_load(ex_op_q);
  assign ex_fwd_ok  = ex_valid_q && !ex_is_load;

  for (genvar p = 0; p < 2; p++) begin : g_opnd
    bp_bypass #(.DW(DW), .RW(RW), .WB_PATH(WB_FWD)) u_byp (
      .src    (ro_src[p]),
      .rf_val (rf_rd[p]),
      .ex_ok  (ex_fwd_ok),
      .ex_dst (ex_dst_q),
      .ex_val (ex_alu),
      .wb_ok  (wb_valid_q),
      .wb_dst (wb_dst_q),
      .wb_val (wb_value),
      .opnd   (opnd[p]),
      .hit_ex (hit_ex[p]),
      .hit_wb (hit_wb[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid_q <= 1'b0;
      ex_op_q    <= OPC_ADD;
      ex_dst_q   <= '0;
      ex_a_q     <= '0;
      ex_b_q     <= '0;
    end else begin
      ex_valid_q <= ro_valid_q && !stall;
      ex_op_q    <= ro_op_q;
      ex_dst_q   <= ro_dst_q;
      ex_a_q     <= opnd[0];
      ex_b_q     <= opnd[1];
    end
  end

  assign ex_alu   = alu_calc(ex_op_q, ex_a_q, ex_b_q);
  assign mem_rd   = ex_valid_q && ex_is_load;
  assign mem_addr = ex_alu[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid_q <= 1'b0;
      wb_op_q    <= OPC_ADD;
      wb_dst_q   <= '0;
      wb_res_q   <= '0;
    end else begin
      wb_valid_q <= ex_valid_q;
      wb_op_q    <= ex_op_q;
      wb_dst_q   <= ex_dst_q;
      wb_res_q   <= ex_alu;
    end
  end

  assign wb_value = op_is_load(wb_op_q) ? mem_rdata : wb_res_q;
  assign in_hold  = stall;
  assign wb_valid = wb_valid_q;
  assign wb_dst   = wb_dst_q;
  assign wb_data  = wb_value;

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R8
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid_q); // R8
  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ro_valid_q && $stable(ro_dst_q) && $stable(ro_srca_q) && $stable(ro_srcb_q))); // R9
  AST_EX_FWD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && hit_ex[0]) |=> (ex_a_q == $past(ex_alu))); // R3
  AST_WB_FWD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && hit_wb[1] && !hit_ex[1]) |=> (ex_b_q == $past(wb_value))); // R5

endmodule

// File: tb/bypass_pipe_tb_top.sv
module bypass_pipe_tb_top;

  localparam int DW = 16;
  localparam int NREG = 8;
  localparam int AW = 6;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [RW-1:0] in_dst = '0, in_srca = '0, in_srcb = '0;

  logic hold0, mrd0, wbv0, hold1, mrd1, wbv1;
  logic [AW-1:0] maddr0, maddr1;
  logic [DW-1:0] mrdata0 = '0, mrdata1 = '0, wbdat0, wbdat1;
  logic [RW-1:0] wbd0, wbd1;

  int checks = 0;
  int fails = 0;
  int stall_cnt = 0;
  string cur_req = "R10";

  logic [DW-1:0] mdl_reg [NREG];
  logic [RW+DW-1:0] expq0 [$];
  logic [RW+DW-1:0] expq1 [$];

  always #5 clk = ~clk;

  bypass_pipe #(.DW(DW), .NREG(NREG), .AW(AW), .READ_NEW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_srca(in_srca), .in_srcb(in_srcb), .in_hold(hold0), .mem_rd(mrd0),
    .mem_addr(maddr0), .mem_rdata(mrdata0), .wb_valid(wbv0), .wb_dst(wbd0), .wb_data(wbdat0));

  bypass_pipe #(.DW(DW), .NREG(NREG), .AW(AW), .READ_NEW(1'b1)) dut_new_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_srca(in_srca), .in_srcb(in_srcb), .in_hold(hold1), .mem_rd(mrd1),
    .mem_addr(maddr1), .mem_rdata(mrdata1), .wb_valid(wbv1), .wb_dst(wbd1), .wb_data(wbdat1));

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    logic [31:0] h;
    h = (32'(a) + 32'd1) * 32'h9E37;
    return h[DW-1:0] ^ 16'h0F0F;
  endfunction

  always_ff @(posedge clk) begin
    if (mrd0) mrdata0 <= mem_word(maddr0);
    if (mrd1) mrdata1 <= mem_word(maddr1);
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // sequential reference of R2
  task automatic model_exec(input logic [1:0] op, input logic [RW-1:0] d,
                            input logic [RW-1:0] a, input logic [RW-1:0] b);
    logic [DW-1:0] va, vb, sum, res;
    va  = mdl_reg[a];
    vb  = mdl_reg[b];
    sum = va + vb;
    case (op)
      2'b01:   res = va - vb;
      2'b10:   res = mem_word(sum[AW-1:0]);
      default: res = sum;
    endcase
    mdl_reg[d] = res;
    expq0.push_back({d, res});
    expq1.push_back({d, res});
  endtask

  task automatic issue(input bit v, input logic [1:0] op, input logic [RW-1:0] d,
                       input logic [RW-1:0] a, input logic [RW-1:0] b);
    @(negedge clk);
    in_valid = v; in_op = op; in_dst = d; in_srca = a; in_srcb = b;
    #1;
    while (hold0) begin
      stall_cnt++;
      check(hold1 == hold0, "R8 hold differs between file policies", 32'(hold1), 32'(hold0));
      @(negedge clk);
      #1;
    end
    if (v) model_exec(op, d, a, b);
  endtask

  task automatic bubbles(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 2'b00, 3'd0, 3'd0, 3'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wbv0) begin
        logic [RW+DW-1:0] e;
        if (expq0.size() == 0) check(1'b0, "R1 unexpected writeback (read-old)", 32'(wbd0), 32'hx);
        else begin
          e = expq0.pop_front();
          check({wbd0, wbdat0} == e, "writeback dst/data (read-old)", 32'({wbd0, wbdat0}), 32'(e));
        end
      end
      if (wbv1) begin
        logic [RW+DW-1:0] e;
        if (expq1.size() == 0) check(1'b0, "R1 unexpected writeback (read-new)", 32'(wbd1), 32'hx);
        else begin
          e = expq1.pop_front();
          check({wbd1, wbdat1} == e, "writeback dst/data (read-new)", 32'({wbd1, wbdat1}), 32'(e));
        end
      end
    end
  end

  task automatic run_all();
    int base;
    logic [31:0] r;
    for (int i = 0; i < NREG; i++) mdl_reg[i] = DW'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    cur_req = "R10";
    check(wbv0 == 1'b0 && wbv1 == 1'b0, "R10 no writeback after reset", 32'(wbv0), 0);
    check(hold0 == 1'b0 && hold1 == 1'b0, "R10 no hold after reset", 32'(hold0), 0);
    issue(1'b1, 2'b00, 3'd1, 3'd2, 3'd3);   // reset values 2+3
    bubbles(4);

    cur_req = "R11";
    issue(1'b1, 2'b00, 3'd0, 3'd3, 3'd4);
    bubbles(3);
    issue(1'b1, 2'b00, 3'd2, 3'd0, 3'd0);
    bubbles(4);

    cur_req = "R3";
    issue(1'b1, 2'b00, 3'd5, 3'd1, 3'd2);
    issue(1'b1, 2'b01, 3'd6, 3'd5, 3'd3);
    issue(1'b1, 2'b01, 3'd7, 3'd4, 3'd6);
    bubbles(4);

    cur_req = "R4";
    issue(1'b1, 2'b00, 3'd4, 3'd1, 3'd1);
    issue(1'b1, 2'b11, 3'd4, 3'd2, 3'd5);
    issue(1'b1, 2'b00, 3'd7, 3'd4, 3'd4);
    bubbles(4);

    cur_req = "R5";
    issue(1'b1, 2'b00, 3'd3, 3'd6, 3'd6);
    issue(1'b1, 2'b00, 3'd0, 3'd1, 3'd1);
    issue(1'b1, 2'b01, 3'd1, 3'd2, 3'd3);
    issue(1'b1, 2'b10, 3'd2, 3'd5, 3'd0);
    bubbles(1);
    issue(1'b1, 2'b00, 3'd6, 3'd2, 3'd2);
    bubbles(4);

    cur_req = "R6";
    issue(1'b1, 2'b01, 3'd2, 3'd7, 3'd1);
    issue(1'b1, 2'b00, 3'd3, 3'd4, 3'd4);
    issue(1'b1, 2'b00, 3'd5, 3'd4, 3'd0);
    issue(1'b1, 2'b00, 3'd6, 3'd0, 3'd0);
    issue(1'b1, 2'b00, 3'd7, 3'd2, 3'd2);
    bubbles(4);

    cur_req = "R7";
    issue(1'b1, 2'b00, 3'd1, 3'd3, 3'd5);
    issue(1'b0, 2'b00, 3'd1, 3'd1, 3'd1);
    issue(1'b0, 2'b10, 3'd4, 3'd1, 3'd1);
    issue(1'b1, 2'b00, 3'd2, 3'd1, 3'd4);
    bubbles(4);

    cur_req = "R8";
    base = stall_cnt;
    issue(1'b1, 2'b10, 3'd4, 3'd1, 3'd2);
    issue(1'b1, 2'b01, 3'd5, 3'd0, 3'd4);
    bubbles(4);
    check(stall_cnt - base == 1, "R8 hold cycles, load feeds second source", 32'(stall_cnt - base), 1);
    base = stall_cnt;
    issue(1'b1, 2'b10, 3'd6, 3'd3, 3'd3);
    issue(1'b1, 2'b00, 3'd7, 3'd6, 3'd1);
    bubbles(4);
    check(stall_cnt - base == 1, "R8 hold cycles, load feeds first source", 32'(stall_cnt - base), 1);
    base = stall_cnt;
    issue(1'b1, 2'b10, 3'd6, 3'd3, 3'd3);
    issue(1'b1, 2'b00, 3'd7, 3'd1, 3'd2);
    bubbles(4);
    check(stall_cnt - base == 0, "R8 hold cycles, independent after load", 32'(stall_cnt - base), 0);

    cur_req = "R9";
    base = stall_cnt;
    issue(1'b1, 2'b10, 3'd3, 3'd1, 3'd0);
    issue(1'b1, 2'b10, 3'd3, 3'd3, 3'd3);
    issue(1'b1, 2'b01, 3'd0, 3'd3, 3'd6);
    issue(1'b1, 2'b00, 3'd1, 3'd0, 3'd3);
    bubbles(4);
    check(stall_cnt - base == 2, "R9 hold cycles, load chain", 32'(stall_cnt - base), 2);

    cur_req = "R1 R2";
    r = $urandom(32'd1234);
    for (int i = 0; i < 3000; i++) begin
      r = $urandom();
      issue(r[4:0] != 5'd0 && r[4:0] != 5'd1 && r[4:0] != 5'd2 ? 1'b1 : 1'b0,
            r[6:5], r[9:7], r[12:10], r[15:13]);
    end
    bubbles(5);
    check(expq0.size() == 0, "R1 results outstanding (read-old)", 32'(expq0.size()), 0);
    check(expq1.size() == 0, "R1 results outstanding (read-new)", 32'(expq1.size()), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule